// File: doc/BRIEF.md
# T1 Frame-Bit Synchronizer

This block takes the framing bit of each T1 frame, one bit per frame, marked by a strobe. It searches for multiframe alignment in one of two formats, chosen by a mode input. The 12-frame format checks every framing bit. The 24-frame extended format checks only one framing bit in four; the other bits belong to the data-link and CRC channels and are never checked. The search tries one candidate alignment at a time. It declares lock only after a full multiframe of sync bits arrives without a single error.

Once locked, the block checks every sync bit. It pulses a frame-bit-error output for one cycle on each mismatch. It declares out-of-frame when two errors fall inside a sliding window of the most recent checked sync bits; the window size is selectable. It reports the multiframe position and the channel type of each accepted bit. Software can force a new search with a resync input, and any change of the mode input has the same effect. Because only two errors in the window drop lock, a 12-frame signal received in extended mode can stay locked at one error every six checks.

Top module: `t1_fsync`

## Requirements
- R1: In 12-frame mode (`esf_mode`=0) every framing bit at position p (0..11) is compared with bit p of 1,0,0,0,1,1,0,1,1,1,0,0. Lock (`locked`=1) is declared on the strobe that completes 12 consecutive matches.
- R2: In 24-frame mode (`esf_mode`=1) only positions p with p mod 4 = 3 are sync bits, expected 0,0,1,0,1,1 for p = 3,7,...,23. Bits at other positions never count as errors. Lock is declared on the 6th consecutive matching sync bit.
- R3: During search, a mismatch clears the match run and holds the candidate position, so the next bit is tested against the same position. A match, or a bit that is not a sync bit, advances the position modulo the multiframe length.
- R4: While locked, a sync-bit mismatch raises `fbe` for exactly the one cycle after the strobe edge. A matching bit leaves `fbe` at 0.
- R5: Out-of-frame is declared when 2 errors lie within the last N checked sync bits while locked. N is 4 for `win_sel`=0, 5 for `win_sel`=1, and 6 for `win_sel`=2 or 3. On that strobe `oof` and `fbe` pulse for one cycle, `locked` falls, and the search restarts at position 0.
- R6: Two errors spaced N or more checked bits apart do not drop lock.
- R7: `resync` high at a clock edge clears `locked`, restarts the search at position 0, and discards any strobe in that cycle. `mf_pos` and `slot_type` keep their values.
- R8: A change of `esf_mode` between two clock edges acts as a forced resync at the second edge.
- R9: On each accepted strobe, `mf_pos` holds the position of that bit and `slot_type` its kind. In 24-frame mode: 0 = data link (even p), 1 = CRC (p mod 4 = 1), 2 = sync (p mod 4 = 3). In 12-frame mode: 2 for even p, 3 for odd p.
- R10: After reset, `locked`, `fbe`, `oof`, `mf_pos` and `slot_type` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fbit_stb | input | 1 | Framing bit valid, one cycle per frame |
| fbit | input | 1 | Framing bit value |
| esf_mode | input | 1 | 0 = 12-frame format, 1 = 24-frame format |
| win_sel | input | 2 | Out-of-frame window: 0 = 4, 1 = 5, 2/3 = 6 bits |
| resync | input | 1 | Forces loss of lock and a fresh search |
| locked | output | 1 | Multiframe alignment held |
| fbe | output | 1 | One-cycle pulse on a sync-bit error while locked |
| oof | output | 1 | One-cycle pulse when out-of-frame is declared |
| mf_pos | output | 5 | Multiframe position of the last accepted bit |
| slot_type | output | 2 | Channel kind of the last accepted bit |

## Verification
The assertions assume that every input is synchronous to the clock and free of X after reset. They also assume that `esf_mode` is held for a full cycle, so the previous sampled mode is the one the checked bit was judged against. The stimulus drives all inputs on the falling edge. It holds each strobe for one cycle with an idle cycle after it, pulses `resync` for single cycles, and changes mode only between strobes. The bench compares against a behavioural model every cycle, and this holds in the random phase as well, where mode flips, window changes, resyncs and bit errors are mixed.

// File: rtl/t1_fsync.sv
module t1_fsync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fbit_stb,
  input  logic       fbit,
  input  logic       esf_mode,
  input  logic [1:0] win_sel,
  input  logic       resync,
  output logic       locked,
  output logic       fbe,
  output logic       oof,
  output logic [4:0] mf_pos,
  output logic [1:0] slot_type
);
  localparam int          HIST    = 6;
  localparam logic [11:0] D4_PAT  = 12'b0011_1011_0001;
  localparam logic [5:0]  FPS_PAT = 6'b11_0100;

  logic            mode_q;
  logic [4:0]      cnt;
  logic [3:0]      run;
  logic [HIST-1:0] hist;

  wire            restart  = resync | (esf_mode != mode_q);
  wire            is_sync  = ~mode_q | (cnt[1:0] == 2'b11);
  wire            exp_bit  = mode_q ? FPS_PAT[cnt[4:2]] : D4_PAT[cnt[3:0]];
  wire            miss     = is_sync & (fbit ^ exp_bit);
  wire [4:0]      cnt_nxt  = (cnt == (mode_q ? 5'd23 : 5'd11)) ? 5'd0 : cnt + 5'd1;
  wire [3:0]      need     = mode_q ? 4'd6 : 4'd12;
  wire [HIST-1:0] hist_nxt = {hist[HIST-2:0], miss};
  wire [HIST-1:0] wmask    = (win_sel == 2'd0) ? 6'b001111 :
                             (win_sel == 2'd1) ? 6'b011111 : 6'b111111;
  wire [2:0]      errs     = 3'($countones(hist_nxt & wmask));
  wire [1:0]      slot_now = mode_q ? (cnt[0] ? {cnt[1], ~cnt[1]} : 2'b00)
                                    : {1'b1, cnt[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      cnt       <= '0;
      run       <= '0;
      hist      <= '0;
      locked    <= 1'b0;
      fbe       <= 1'b0;
      oof       <= 1'b0;
      mf_pos    <= '0;
      slot_type <= '0;
    end else begin
      mode_q <= esf_mode;
      fbe    <= 1'b0;
      oof    <= 1'b0;
      if (restart) begin
        locked <= 1'b0;
        cnt    <= '0;
        run    <= '0;
        hist   <= '0;
      end else if (fbit_stb) begin
        mf_pos    <= cnt;
        slot_type <= slot_now;
        if (locked) begin
          cnt <= cnt_nxt;
          if (is_sync) begin
            hist <= hist_nxt;
            fbe  <= miss;
            if (miss && errs >= 3'd2) begin
              oof    <= 1'b1;
              locked <= 1'b0;
              cnt    <= '0;
              run    <= '0;
              hist   <= '0;
            end
          end
        end else if (miss) begin
          run <= '0;
        end else begin
          cnt <= cnt_nxt;
          if (is_sync) begin
            if (run == need - 4'd1) begin
              locked <= 1'b1;
              run    <= '0;
              hist   <= '0;
            end else begin
              run <= run + 4'd1;
            end
          end
        end
      end
    end
  end
endmodule

module t1_fsync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fbit_stb,
  input logic       fbit,
  input logic       esf_mode,
  input logic [1:0] win_sel,
  input logic       resync,
  input logic       locked,
  input logic       fbe,
  input logic       oof,
  input logic [4:0] mf_pos,
  input logic [1:0] slot_type
);
  assert_clean_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !fbe && !oof && $past(fbit_stb));

  assert_esf_fbe_on_fps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fbe && $past(esf_mode)) |-> slot_type == 2'b10);

  assert_fbe_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fbe |-> $past(locked) && $past(fbit_stb));

  assert_oof_drops_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oof |-> fbe && !locked);

  assert_resync_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !locked && !fbe && !oof);

  assert_mode_change_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (esf_mode != $past(esf_mode)) |=> !locked);

  assert_pos_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mf_pos < 5'd24);
endmodule

bind t1_fsync t1_fsync_chk u_chk (.*);

// File: tb/sim_t1_fsync.sv
`timescale 1ns/1ps
module sim_t1_fsync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fbit_stb = 1'b0;
  logic       fbit = 1'b0;
  logic       esf_mode = 1'b0;
  logic [1:0] win_sel = 2'd2;
  logic       resync = 1'b0;
  logic       locked, fbe, oof;
  logic [4:0] mf_pos;
  logic [1:0] slot_type;

  always #2.5 clk = ~clk;

  t1_fsync u0 (.clk(clk), .rst_n(rst_n), .fbit_stb(fbit_stb), .fbit(fbit),
               .esf_mode(esf_mode), .win_sel(win_sel), .resync(resync),
               .locked(locked), .fbe(fbe), .oof(oof), .mf_pos(mf_pos),
               .slot_type(slot_type));

  int n_chk = 0, n_fail = 0, cyc = 0, sidx = 0;
  bit running = 0;
  int d4[12]  = '{1,0,0,0,1,1,0,1,1,1,0,0};
  int fps[6]  = '{0,0,1,0,1,1};

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_of(bit m, int p);
    if (!m) return d4[p];
    if (p % 4 != 3) return -1;
    return fps[p / 4];
  endfunction

  function automatic int slot_of(bit m, int p);
    if (!m) return (p % 2 == 0) ? 2 : 3;
    if (p % 4 == 1) return 1;
    if (p % 4 == 3) return 2;
    return 0;
  endfunction

  function automatic bit gen(int idx);
    if (!esf_mode) return d4[idx % 12] != 0;
    if (idx % 4 == 3) return fps[(idx % 24) / 4] != 0;
    return $urandom % 2 == 1;
  endfunction

  // behavioural reference
  int m_locked, m_fbe, m_oof, m_mfpos, m_slot, m_pos, m_run, m_e, m_len, m_need, m_errs, m_win;
  bit m_prev;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_locked = 0; m_fbe = 0; m_oof = 0; m_mfpos = 0; m_slot = 0;
      m_pos = 0; m_run = 0; m_prev = 0; q.delete();
    end else begin
      m_fbe = 0; m_oof = 0;
      if (resync || esf_mode != m_prev) begin
        m_locked = 0; m_pos = 0; m_run = 0; q.delete();
      end else if (fbit_stb) begin
        m_len  = esf_mode ? 24 : 12;
        m_need = esf_mode ? 6 : 12;
        m_win  = (win_sel == 0) ? 4 : (win_sel == 1) ? 5 : 6;
        m_e    = exp_of(esf_mode, m_pos);
        m_mfpos = m_pos;
        m_slot  = slot_of(esf_mode, m_pos);
        if (m_locked != 0) begin
          m_pos = (m_pos + 1) % m_len;
          if (m_e >= 0) begin
            q.push_back(int'(fbit) != m_e ? 1 : 0);
            if (q.size() > 6) void'(q.pop_front());
            m_fbe = (int'(fbit) != m_e) ? 1 : 0;
            m_errs = 0;
            for (int i = 0; i < m_win; i++)
              if (i < q.size()) m_errs += q[q.size() - 1 - i];
            if (m_fbe == 1 && m_errs >= 2) begin
              m_oof = 1; m_locked = 0; m_pos = 0; m_run = 0; q.delete();
            end
          end
        end else if (m_e < 0) begin
          m_pos = (m_pos + 1) % m_len;
        end else if (int'(fbit) == m_e) begin
          m_pos = (m_pos + 1) % m_len;
          m_run++;
          if (m_run == m_need) begin
            m_locked = 1; m_run = 0; q.delete();
          end
        end else begin
          m_run = 0;
        end
      end
      m_prev = esf_mode;
    end
  end

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("R5 locked", int'(locked), m_locked);
      chk("R4 fbe", int'(fbe), m_fbe);
      chk("R5 oof", int'(oof), m_oof);
      chk("R9 mf_pos", int'(mf_pos), m_mfpos);
      chk("R9 slot_type", int'(slot_type), m_slot);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send(bit b);
    @(negedge clk);
    fbit_stb = 1'b1;
    fbit = b;
    @(negedge clk);
    fbit_stb = 1'b0;
  endtask

  task automatic good(int n);
    for (int i = 0; i < n; i++) begin
      send(gen(sidx));
      sidx++;
    end
  endtask

  task automatic bad();
    send(!gen(sidx));
    sidx++;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    chk("R10 locked", int'(locked), 0);
    chk("R10 fbe", int'(fbe), 0);
    chk("R10 oof", int'(oof), 0);
    chk("R10 mf_pos", int'(mf_pos), 0);
    chk("R10 slot_type", int'(slot_type), 0);

    // search with slides (12-frame mode, window 6)
    send(1'b0);
    chk("R3 held pos", int'(mf_pos), 0);
    chk("R9 slot even", int'(slot_type), 2);
    sidx = 0;
    good(1);
    chk("R3 retest pos", int'(mf_pos), 0);
    good(4);
    send(1'b0);
    chk("R3 mismatch pos", int'(mf_pos), 5);
    chk("R9 slot odd", int'(slot_type), 3);
    good(11);
    chk("R1 not yet", int'(locked), 0);
    good(1);
    chk("R1 lock", int'(locked), 1);
    chk("R1 lock pos", int'(mf_pos), 4);

    bad();
    chk("R4 fbe", int'(fbe), 1);
    chk("R4 still locked", int'(locked), 1);
    @(negedge clk);
    chk("R4 one cycle", int'(fbe), 0);
    good(5);
    bad();
    chk("R6 spaced errors keep lock", int'(locked), 1);
    chk("R6 oof quiet", int'(oof), 0);
    good(4);
    bad();
    chk("R5 oof N6", int'(oof), 1);
    chk("R5 unlock", int'(locked), 0);
    @(negedge clk);
    chk("R5 oof pulse", int'(oof), 0);

    sidx = 0; good(12);
    chk("R1 relock", int'(locked), 1);
    win_sel = 2'd0;
    bad(); good(3); bad();
    chk("R6 N4 keep", int'(locked), 1);
    good(2); bad();
    chk("R5 oof N4", int'(oof), 1);

    sidx = 0; good(12);
    win_sel = 2'd1;
    bad(); good(4); bad();
    chk("R6 N5 keep", int'(locked), 1);
    good(3); bad();
    chk("R5 oof N5", int'(oof), 1);
    chk("R5 unlock N5", int'(locked), 0);

    // forced resync
    win_sel = 2'd2;
    sidx = 0; good(12);
    @(negedge clk);
    fbit_stb = 1'b1; fbit = !gen(sidx); resync = 1'b1;
    @(negedge clk);
    fbit_stb = 1'b0; resync = 1'b0;
    chk("R7 unlock", int'(locked), 0);
    chk("R7 no fbe", int'(fbe), 0);
    chk("R7 pos kept", int'(mf_pos), 11);

    // mode change
    sidx = 0; good(12);
    chk("R1 lock again", int'(locked), 1);
    esf_mode = 1'b1;
    @(negedge clk);
    chk("R8 mode change unlock", int'(locked), 0);
    sidx = 0;
    good(1);
    chk("R9 fdl slot", int'(slot_type), 0);
    good(1);
    chk("R9 crc slot", int'(slot_type), 1);
    good(2);
    chk("R9 fps slot", int'(slot_type), 2);
    chk("R9 fps pos", int'(mf_pos), 3);
    good(19);
    chk("R2 not yet", int'(locked), 0);
    good(1);
    chk("R2 lock", int'(locked), 1);
    send(1'b0);
    chk("R2 fdl ignored", int'(fbe), 0);
    send(1'b1);
    chk("R2 crc ignored", int'(fbe), 0);
    sidx = 26;
    good(1);
    bad();
    chk("R2 fps checked", int'(fbe), 1);
    chk("R2 still locked", int'(locked), 1);

    // 12-frame stream received in 24-frame mode
    for (int k = 0; k < 240; k++) send(d4[k % 12] != 0);

    // mixed random phase
    for (int k = 0; k < 600; k++) begin
      if ($urandom % 97 == 0) esf_mode = !esf_mode;
      if ($urandom % 41 == 0) win_sel = 2'($urandom % 4);
      if ($urandom % 131 == 0) begin
        @(negedge clk); resync = 1'b1;
        @(negedge clk); resync = 1'b0;
        sidx = 0;
      end
      if ($urandom % 23 == 0) bad(); else good(1);
    end

    @(negedge clk);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule